// File: doc/BRIEF.md
# Sector Erase Queue Timer

This block collects sector-erase requests for a flash command decoder and turns them into one concurrent erase. The first accepted sector-erase command opens an acceptance window and records its sector as a one-hot bit in an eight-bit selection mask. While the window stays open, further sector-erase commands add their sectors to the mask in any order. Every write-enable falling edge restarts the quiet timer. Any other command cancels the queue and returns the decoder to read mode.

The window length is a count of system clock cycles, taken as `CLK_MHZ * WINDOW_US`. With the default values this is 8000 cycles, or 80 µs. When that many cycles pass after the last command or write edge, the block pulses `erase_start` for one cycle and presents the mask. It then ignores all further traffic until the erase engine reports completion. The sector number is the 3-bit field that the decoder takes from address bits 16:14.

Top module: `sector_erase_queue`

## Requirements
- R1: After reset, `window_open`, `erase_active` and `erase_start` are 0 and `erase_mask` is all zeros.
- R2: In the idle state, a pulse on `cmd_sec_erase` opens the window on the next cycle. `erase_mask` then equals one-hot bit n, where n is `cmd_sector`.
- R3: While the window is open, each `cmd_sec_erase` pulse sets bit `cmd_sector` of the mask in addition to the bits already set, and sectors may arrive in any order. A sector that is already queued leaves the mask unchanged but still restarts the timer.
- R4: While the window is open, a `we_fall` pulse restarts the quiet timer without changing the mask.
- R5: The quiet time is `CLK_MHZ*WINDOW_US` cycles. It runs from the clock edge that samples the last event, where an event is a first or further sector-erase command or a write edge. When that many cycles pass with no event, the block does three things on that edge:
  - `erase_start` goes high for exactly one cycle;
  - `window_open` falls;
  - `erase_active` rises, with the queued mask on `erase_mask`.
- R6: A `cmd_other` pulse while the window is open closes the window, clears the mask and produces no `erase_start`. It wins over a `cmd_sec_erase` pulse in the same cycle.
- R7: While `erase_active` is high, `cmd_sec_erase`, `cmd_other` and `we_fall` have no effect, and `erase_mask` holds its value.
- R8: An `erase_done` pulse during the erase returns the block to idle with the mask cleared. In idle, `cmd_other`, `we_fall` and `erase_done` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_sec_erase | input | 1 | One-cycle pulse: a sector-erase command was accepted |
| cmd_sector | input | 3 | Sector number (address bits 16:14) sent with `cmd_sec_erase` |
| we_fall | input | 1 | One-cycle pulse: a write-enable falling edge was seen |
| cmd_other | input | 1 | One-cycle pulse: a command other than sector erase was accepted |
| erase_done | input | 1 | One-cycle pulse from the erase engine: the erase finished |
| window_open | output | 1 | The acceptance window is open |
| erase_active | output | 1 | An erase is in progress |
| erase_start | output | 1 | One-cycle pulse: start the erase of the sectors in `erase_mask` |
| erase_mask | output | 8 | Queued sectors, with bit n meaning sector n |

## Verification
The bench places queued commands and write edges at every gap up to one cycle short of expiry. A timer that failed to restart, or that counted one cycle off, would start the erase early or late, and the check on the exact start cycle would catch it. Duplicate sectors and reverse or random ordering are mixed in, so a mask that overwrote bits instead of ORing them would drop sectors. Aborts arrive both alone and together with a sector-erase command, so a design that let the queue survive would produce a start pulse. Commands sent during the erase are checked against a mask that must stay frozen and against `erase_start`, which must not pulse again.

// File: rtl/sxq_pkg.sv
package sxq_pkg;

  typedef enum logic [1:0] {
    SXQ_IDLE  = 2'd0,
    SXQ_WIN   = 2'd1,
    SXQ_ERASE = 2'd2
  } sxq_state_e;

endpackage

// File: rtl/sxq_timer.sv
module sxq_timer #(
  parameter int CYCLES = 8000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic at_last
);
  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (restart) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (run && (cnt_q != LAST)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign at_last = run && (cnt_q == LAST);

endmodule

// File: rtl/sxq_mask.sv
module sxq_mask #(
  parameter int N_SECT = 8,
  localparam int SEL_W = $clog2(N_SECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              add,
  input  logic [SEL_W-1:0]  sel,
  output logic [N_SECT-1:0] mask
);
  for (genvar i = 0; i < N_SECT; i++) begin : g_bit
    logic hit, bit_en, bit_d, bit_q;

    always_comb begin
      hit    = add && (sel == SEL_W'(i));
      bit_en = clear || hit;
      bit_d  = !clear;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= 1'b0;
      else if (bit_en) bit_q <= bit_d;
    end

    assign mask[i] = bit_q;
  end

endmodule

// File: rtl/sxq_ctrl.sv
module sxq_ctrl
  import sxq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_sec_erase,
  input  logic cmd_other,
  input  logic we_fall,
  input  logic erase_done,
  input  logic at_last,
  output logic timer_run,
  output logic timer_restart,
  output logic mask_add,
  output logic mask_clear,
  output logic window_open,
  output logic erase_active,
  output logic erase_start
);
  sxq_state_e state_q, state_d;
  logic       start_q, start_d;
  logic       accept, quiet;

  always_comb begin
    accept        = cmd_sec_erase && !cmd_other;
    quiet         = !accept && !we_fall && !cmd_other;
    state_d       = state_q;
    start_d       = 1'b0;
    timer_restart = 1'b0;
    mask_add      = 1'b0;
    mask_clear    = 1'b0;
    unique case (state_q)
      SXQ_IDLE: begin
        if (accept) begin
          state_d       = SXQ_WIN;
          mask_add      = 1'b1;
          timer_restart = 1'b1;
        end
      end
      SXQ_WIN: begin
        if (cmd_other) begin
          state_d    = SXQ_IDLE;
          mask_clear = 1'b1;
        end else if (accept || we_fall) begin
          mask_add      = accept;
          timer_restart = 1'b1;
        end else if (quiet && at_last) begin
          state_d = SXQ_ERASE;
          start_d = 1'b1;
        end
      end
      SXQ_ERASE: begin
        if (erase_done) begin
          state_d    = SXQ_IDLE;
          mask_clear = 1'b1;
        end
      end
      default: begin
        state_d    = SXQ_IDLE;
        mask_clear = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SXQ_IDLE;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
    end
  end

  assign timer_run    = (state_q == SXQ_WIN);
  assign window_open  = (state_q == SXQ_WIN);
  assign erase_active = (state_q == SXQ_ERASE);
  assign erase_start  = start_q;

endmodule

// File: rtl/sector_erase_queue.sv
module sector_erase_queue #(
  parameter int CLK_MHZ   = 100,
  parameter int WINDOW_US = 80,
  parameter int N_SECT    = 8,
  localparam int SEL_W    = $clog2(N_SECT),
  localparam int TIMEOUT  = CLK_MHZ * WINDOW_US
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_sec_erase,
  input  logic [SEL_W-1:0]  cmd_sector,
  input  logic              we_fall,
  input  logic              cmd_other,
  input  logic              erase_done,
  output logic              window_open,
  output logic              erase_active,
  output logic              erase_start,
  output logic [N_SECT-1:0] erase_mask
);
  logic timer_run, timer_restart, at_last, mask_add, mask_clear;

  sxq_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_sec_erase (cmd_sec_erase),
    .cmd_other     (cmd_other),
    .we_fall       (we_fall),
    .erase_done    (erase_done),
    .at_last       (at_last),
    .timer_run     (timer_run),
    .timer_restart (timer_restart),
    .mask_add      (mask_add),
    .mask_clear    (mask_clear),
    .window_open   (window_open),
    .erase_active  (erase_active),
    .erase_start   (erase_start)
  );

  sxq_timer #(.CYCLES(TIMEOUT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (timer_run),
    .restart (timer_restart),
    .at_last (at_last)
  );

  sxq_mask #(.N_SECT(N_SECT)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (mask_clear),
    .add   (mask_add),
    .sel   (cmd_sector),
    .mask  (erase_mask)
  );

endmodule

// File: rtl/sxq_checker.sv
module sxq_checker #(
  parameter int N_SECT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_sec_erase,
  input logic              cmd_other,
  input logic              erase_done,
  input logic              window_open,
  input logic              erase_active,
  input logic              erase_start,
  input logic [N_SECT-1:0] erase_mask
);
  AST_IDLE_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!window_open && !erase_active) |-> (erase_mask == '0)); // R1
  AST_WINDOW_HAS_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    window_open |-> (erase_mask != '0)); // R2
  AST_MASK_ONLY_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (window_open && !cmd_other) |=> ((erase_mask & $past(erase_mask)) == $past(erase_mask))); // R3
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start); // R5
  AST_START_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> ($past(window_open) && erase_active && !window_open)); // R5
  AST_ABORT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (window_open && cmd_other) |=> (!window_open && !erase_active && !erase_start)); // R6
  AST_ERASE_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_active && !erase_done) |=> ($stable(erase_mask) && erase_active)); // R7
  AST_STATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(window_open && erase_active)); // R8
  AST_DONE_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_active && erase_done) |=> (!erase_active && !window_open)); // R8
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!window_open && !erase_active && !cmd_sec_erase) |=> (!window_open && !erase_active)); // R8

endmodule

bind sector_erase_queue sxq_checker #(.N_SECT(N_SECT)) u_sxq_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_sec_erase (cmd_sec_erase),
  .cmd_other     (cmd_other),
  .erase_done    (erase_done),
  .window_open   (window_open),
  .erase_active  (erase_active),
  .erase_start   (erase_start),
  .erase_mask    (erase_mask)
);

// File: tb/sector_erase_queue_tb.sv
module sector_erase_queue_tb;
  localparam int T = 80;

  logic       clk, rst_n;
  logic       cmd_sec_erase, we_fall, cmd_other, erase_done;
  logic [2:0] cmd_sector;
  logic       window_open, erase_active, erase_start;
  logic [7:0] erase_mask;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  sector_erase_queue #(.CLK_MHZ(1), .WINDOW_US(T), .N_SECT(8)) u_dut (
    .clk (clk), .rst_n (rst_n), .cmd_sec_erase (cmd_sec_erase),
    .cmd_sector (cmd_sector), .we_fall (we_fall), .cmd_other (cmd_other),
    .erase_done (erase_done), .window_open (window_open),
    .erase_active (erase_active), .erase_start (erase_start),
    .erase_mask (erase_mask)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] onehot(input logic [2:0] s);
    return 8'(1) << s;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // state word: {erase_start, erase_active, window_open, mask}
  function automatic logic [10:0] st();
    return {erase_start, erase_active, window_open, erase_mask};
  endfunction

  task automatic expect_st(input string req, input bit s, input bit a, input bit w, input logic [7:0] m);
    check(st() == {s, a, w, m}, req, st(), {s, a, w, m});
  endtask

  task automatic p_sec(input logic [2:0] s);
    cmd_sec_erase = 1'b1; cmd_sector = s;
    @(negedge clk);
    cmd_sec_erase = 1'b0;
  endtask
  task automatic p_we();
    we_fall = 1'b1; @(negedge clk); we_fall = 1'b0;
  endtask
  task automatic p_other();
    cmd_other = 1'b1; @(negedge clk); cmd_other = 1'b0;
  endtask
  task automatic p_done();
    erase_done = 1'b1; @(negedge clk); erase_done = 1'b0;
  endtask

  // Called right after the last event pulse: expiry must come exactly T edges later.
  task automatic expect_expiry(input logic [7:0] m);
    repeat (T - 1) @(negedge clk);
    expect_st("R5 window still open one cycle before expiry", 0, 0, 1, m);
    @(negedge clk);
    expect_st("R5 start pulse at expiry", 1, 1, 0, m);
    @(negedge clk);
    expect_st("R5 start lasts one cycle", 0, 1, 0, m);
  endtask

  task automatic finish_erase(input logic [7:0] m);
    p_sec(3'(m[2:0] + 3'd1));
    p_other();
    p_we();
    expect_st("R7 commands ignored during erase", 0, 1, 0, m);
    p_done();
    expect_st("R8 done returns to idle", 0, 0, 0, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_m;
    cmd_sec_erase = 0; we_fall = 0; cmd_other = 0; erase_done = 0; cmd_sector = 0;
    rst_n = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    expect_st("R1 reset state", 0, 0, 0, 8'h00);
    rst_n = 1;
    @(negedge clk);
    expect_st("R1 after release", 0, 0, 0, 8'h00);

    // R8: idle ignores other traffic
    p_other(); p_we(); p_done();
    expect_st("R8 idle ignores traffic", 0, 0, 0, 8'h00);

    // R2 single sector
    p_sec(3'd5);
    expect_st("R2 first command opens window", 0, 0, 1, onehot(3'd5));
    expect_expiry(onehot(3'd5));
    finish_erase(onehot(3'd5));

    // R3 reverse order, duplicate restarts timer
    p_sec(3'd7);
    repeat (T - 2) @(negedge clk);
    p_sec(3'd0);
    repeat (T - 2) @(negedge clk);
    p_sec(3'd7);
    expect_st("R3 duplicate leaves mask", 0, 0, 1, 8'h81);
    expect_expiry(8'h81);
    finish_erase(8'h81);

    // R4 write edge restarts timer at the last possible cycle
    p_sec(3'd2);
    repeat (T - 2) @(negedge clk);
    p_we();
    expect_st("R4 write edge keeps window and mask", 0, 0, 1, onehot(3'd2));
    expect_expiry(onehot(3'd2));
    finish_erase(onehot(3'd2));

    // R6 abort alone and abort together with sector command
    p_sec(3'd3);
    p_sec(3'd4);
    p_other();
    expect_st("R6 abort clears queue", 0, 0, 0, 8'h00);
    repeat (T + 2) @(negedge clk);
    expect_st("R6 no start after abort", 0, 0, 0, 8'h00);
    p_sec(3'd1);
    cmd_other = 1; cmd_sec_erase = 1; cmd_sector = 3'd6;
    @(negedge clk);
    cmd_other = 0; cmd_sec_erase = 0;
    expect_st("R6 abort wins over simultaneous sector", 0, 0, 0, 8'h00);

    // Random phase
    for (int it = 0; it < 40; it++) begin
      int n, g;
      logic [2:0] s;
      bit abort;
      n = 1 + int'($urandom_range(0, 4));
      abort = ($urandom_range(0, 5) == 0);
      exp_m = 8'h00;
      for (int k = 0; k < n; k++) begin
        s = 3'($urandom_range(0, 7));
        p_sec(s);
        exp_m |= onehot(s);
        if ($urandom_range(0, 1) == 1) begin
          g = int'($urandom_range(0, T - 3));
          repeat (g) @(negedge clk);
          p_we();
        end
        g = int'($urandom_range(0, T - 2));
        if (k != n - 1) repeat (g) @(negedge clk);
      end
      expect_st("R3 random queued mask", 0, 0, 1, exp_m);
      if (abort) begin
        p_other();
        expect_st("R6 random abort", 0, 0, 0, 8'h00);
      end else begin
        expect_expiry(exp_m);
        finish_erase(exp_m);
      end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule